// File: doc/BRIEF.md
# Indexed Indirect Effective Address Resolver

This block turns a 36-bit instruction word into the 18-bit effective address that the instruction works on. The word is read with bit 0 as the most significant bit. The resolver takes the word's address field. When the index field names a register, it adds the right half of that register. When the indirect flag is set, it reads a fresh word from memory at the resulting address and starts again with that word's indirect, index and address fields. It repeats this for as many levels as the chain runs, and stops when it reaches a word whose indirect flag is clear.

The resolver sits between instruction decode and execution. A single-cycle `start` strobe loads the instruction. While the resolver is busy it reads the register file through a combinational read port (`reg_sel` out, `reg_data` back in the same cycle). It reaches memory through a request/response pair. When the chain ends, it pulses `done` and presents the effective address together with the opcode and accumulator fields of the original instruction. An `abort` input ends a chain that would never terminate.

Top module: `ea_resolver`

## Requirements
- R1: Instruction field layout, with port bit 35 being bit 0. The opcode is `instr[35:27]`, the accumulator field is `instr[26:23]`, the indirect flag is `instr[22]`, the index field is `instr[21:18]` and the address field is `instr[17:0]`. Words fetched from memory use the same layout.
- R2: An index field of 0 means no indexing. The address field passes through unchanged, and the contents of register 0 have no effect on the result.
- R3: An index field of 1 to 15 adds bits [17:0] of that register to the address field, modulo 2^18. Bits [35:18] of the register have no effect.
- R4: When the current word has its indirect flag set, the resolver reads memory at the indexed address. The fetched word's indirect, index and address fields then become the current word. This repeats for any number of levels until a word with a clear indirect flag is reached.
- R5: The opcode and accumulator outputs always come from the original instruction. The opcode and accumulator fields of fetched words have no effect on them.
- R6: When the instruction's indirect flag is clear, `done` rises on the second rising edge after the edge that samples `start`, and no memory request is made.
- R7: `done` is high for exactly one cycle. `ea`, `op_out` and `ac_out` are valid in that cycle.
- R8: `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_rvalid` is sampled high.
- R9: When `abort` is sampled high while the resolver is resolving (busy, and not in the done cycle), the resolver returns to idle on the next edge with `busy`, `done` and `mem_req` all low. It never signals `done` for that instruction.
- R10: `start` is ignored while `busy` is high. The chain in progress completes with its own address, opcode and accumulator.
- R11: During reset and after it, `busy`, `done` and `mem_req` are low until a `start` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `instr` and begin resolving (accepted only when idle) |
| instr | input | 36 | Instruction word |
| abort | input | 1 | Cancel the resolution in progress |
| busy | output | 1 | Resolver is not idle |
| reg_sel | output | 4 | Register file read index |
| reg_data | input | 36 | Register file read data for `reg_sel`, same cycle |
| mem_req | output | 1 | Memory read request, held until the response |
| mem_addr | output | 18 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 36 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 18 | Resolved effective address |
| op_out | output | 9 | Opcode of the original instruction |
| ac_out | output | 4 | Accumulator field of the original instruction |

## Verification
The bench drives the resolver with direct words, with and without indexing. It uses a register 0 loaded with non-zero data, so that skipped indexing is told apart from an add of zero. An index register with a non-zero left half shows that only the right half is used. Offsets such as all ones and the top bit alone force the modulo-2^18 wrap. Indirect chains of one, two and four levels mix indexing inside the chain and use memory latencies of zero to two cycles, which tells a single indirect step apart from a true loop. A fetched word with foreign opcode and accumulator bits separates the original instruction's fields from the fetched ones. A self-referencing indirect word is cut off by `abort`, and a second `start` is issued in the middle of a chain.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int WORD_W  = 36;
  localparam int ADDR_W  = 18;
  localparam int IDX_W   = 4;
  localparam int AC_W    = 4;
  localparam int OP_W    = WORD_W - ADDR_W - IDX_W - 1 - AC_W;
  localparam int NREG    = 1 << IDX_W;
  localparam int IND_POS = ADDR_W + IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INDEX = 2'd1,
    ST_MWAIT = 2'd2,
    ST_DONE  = 2'd3
  } ea_state_t;

  // Most significant field first: bit 0 of the word is the port MSB.
  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [AC_W-1:0]   ac;
    logic              ind;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
  } ea_word_t;

  function automatic ea_word_t split_word(input logic [WORD_W-1:0] w);
    return ea_word_t'(w);
  endfunction

  // Address arithmetic wraps at 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] ea_add(input logic [ADDR_W-1:0] base,
                                               input logic [ADDR_W-1:0] off,
                                               input logic              use_off);
    logic [ADDR_W-1:0] term;
    term = use_off ? off : '0;
    return base + term;
  endfunction
endpackage

// File: rtl/ea_field_split.sv
module ea_field_split
  import ea_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [OP_W-1:0]   op,
  output logic [AC_W-1:0]   ac,
  output logic              ind,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  ea_word_t f;

  always_comb begin
    f    = split_word(word);
    op   = f.op;
    ac   = f.ac;
    ind  = f.ind;
    idx  = f.idx;
    addr = f.addr;
  end
endmodule

// File: rtl/ea_index_adder.sv
module ea_index_adder
  import ea_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] reg_rhalf,
  output logic [IDX_W-1:0]  reg_sel,
  output logic              idx_used,
  output logic [ADDR_W-1:0] sum
);
  always_comb begin
    reg_sel  = idx;
    idx_used = (idx != '0);
    sum      = ea_add(base, reg_rhalf, idx_used);
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      abort,
  input  logic      cur_ind,
  input  logic      mem_rvalid,
  output ea_state_t state,
  output logic      take_instr,
  output logic      take_fetch,
  output logic      go_mem,
  output logic      finish,
  output logic      abort_taken
);
  ea_state_t nxt;

  always_comb begin
    nxt        = state;
    take_instr = 1'b0;
    take_fetch = 1'b0;
    go_mem     = 1'b0;
    finish     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          nxt        = ST_INDEX;
          take_instr = 1'b1;
        end
      end
      ST_INDEX: begin
        if (abort) begin
          nxt = ST_IDLE;
        end else if (cur_ind) begin
          nxt    = ST_MWAIT;
          go_mem = 1'b1;
        end else begin
          nxt    = ST_DONE;
          finish = 1'b1;
        end
      end
      ST_MWAIT: begin
        if (abort) begin
          nxt = ST_IDLE;
        end else if (mem_rvalid) begin
          nxt        = ST_INDEX;
          take_fetch = 1'b1;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign abort_taken = abort && ((state == ST_INDEX) || (state == ST_MWAIT));

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic              abort,
  output logic              busy,
  output logic [IDX_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] reg_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [OP_W-1:0]   op_out,
  output logic [AC_W-1:0]   ac_out
);
  // Decoded instruction fields
  logic [OP_W-1:0]   in_op;
  logic [AC_W-1:0]   in_ac;
  logic              in_ind;
  logic [IDX_W-1:0]  in_idx;
  logic [ADDR_W-1:0] in_addr;

  // Decoded fetched-word fields
  logic [OP_W-1:0]   unused_f_op;
  logic [AC_W-1:0]   unused_f_ac;
  logic              f_ind;
  logic [IDX_W-1:0]  f_idx;
  logic [ADDR_W-1:0] f_addr;

  // Current link of the chain
  logic              cur_ind;
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] cur_addr;

  logic [OP_W-1:0]   op_q;
  logic [AC_W-1:0]   ac_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [ADDR_W-1:0] ea_q;

  // Named internal events, observed by the checker
  ea_state_t         state;
  logic              take_instr;
  logic              chain_step;
  logic              go_mem;
  logic              finish;
  logic              abort_taken;
  logic              idx_used;
  logic [ADDR_W-1:0] step_sum;

  // Only the right half of an index register takes part in the add
  logic unused_reg_hi;
  assign unused_reg_hi = ^reg_data[WORD_W-1:ADDR_W];

  ea_field_split u_split_instr (
    .word (instr),
    .op   (in_op),
    .ac   (in_ac),
    .ind  (in_ind),
    .idx  (in_idx),
    .addr (in_addr)
  );

  ea_field_split u_split_fetch (
    .word (mem_rdata),
    .op   (unused_f_op),
    .ac   (unused_f_ac),
    .ind  (f_ind),
    .idx  (f_idx),
    .addr (f_addr)
  );

  ea_index_adder u_adder (
    .base      (cur_addr),
    .idx       (cur_idx),
    .reg_rhalf (reg_data[ADDR_W-1:0]),
    .reg_sel   (reg_sel),
    .idx_used  (idx_used),
    .sum       (step_sum)
  );

  ea_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .abort       (abort),
    .cur_ind     (cur_ind),
    .mem_rvalid  (mem_rvalid),
    .state       (state),
    .take_instr  (take_instr),
    .take_fetch  (chain_step),
    .go_mem      (go_mem),
    .finish      (finish),
    .abort_taken (abort_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q       <= '0;
      ac_q       <= '0;
      cur_ind    <= 1'b0;
      cur_idx    <= '0;
      cur_addr   <= '0;
      mem_addr_q <= '0;
      ea_q       <= '0;
    end else begin
      if (take_instr) begin
        op_q     <= in_op;
        ac_q     <= in_ac;
        cur_ind  <= in_ind;
        cur_idx  <= in_idx;
        cur_addr <= in_addr;
      end else if (chain_step) begin
        cur_ind  <= f_ind;
        cur_idx  <= f_idx;
        cur_addr <= f_addr;
      end
      if (go_mem) mem_addr_q <= step_sum;
      if (finish) ea_q       <= step_sum;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign mem_req  = (state == ST_MWAIT);
  assign mem_addr = mem_addr_q;
  assign ea       = ea_q;
  assign op_out   = op_q;
  assign ac_out   = ac_q;
endmodule

// File: rtl/ea_resolver_chk.sv
module ea_resolver_chk
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] instr,
  input logic              abort,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              done,
  input logic [OP_W-1:0]   op_out,
  input logic [AC_W-1:0]   ac_out,
  input logic              chain_step,
  input logic              abort_taken
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && !abort) |=> (mem_req && $stable(mem_addr)));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_taken |=> (!busy && !done && !mem_req));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start && !abort) |=> busy);

  // R5
  orig_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(op_out) && $stable(ac_out)));

  // R4
  chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_step |=> (busy && !mem_req && !done));

  // R6
  direct_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((start && !busy && !instr[IND_POS]) ##1 !abort) |=> (done && !mem_req));
endmodule

bind ea_resolver ea_resolver_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .instr       (instr),
  .abort       (abort),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_rvalid  (mem_rvalid),
  .done        (done),
  .op_out      (op_out),
  .ac_out      (ac_out),
  .chain_step  (chain_step),
  .abort_taken (abort_taken)
);

// File: tb/sim_ea_resolver.sv
`timescale 1ns/1ps
module sim_ea_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [35:0] instr;
  logic        abort;
  logic        busy;
  logic [3:0]  reg_sel;
  logic [35:0] reg_data;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_rvalid;
  logic [35:0] mem_rdata;
  logic        done;
  logic [17:0] ea;
  logic [8:0]  op_out;
  logic [3:0]  ac_out;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int lat    = 0;
  int addr_moves = 0;
  int bad_addr   = 0;

  logic [35:0] regs [16];
  logic [35:0] mem  [64];

  always #4 clk = ~clk;   // 125 MHz

  assign reg_data = regs[reg_sel];

  ea_resolver u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .abort(abort),
    .busy(busy), .reg_sel(reg_sel), .reg_data(reg_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .ea(ea), .op_out(op_out), .ac_out(ac_out)
  );

  // Word builder, R1 layout: op[35:27] ac[26:23] ind[22] idx[21:18] addr[17:0]
  function automatic logic [35:0] mkw(input int op, input int ac, input int ind,
                                      input int idx, input int addr);
    logic [35:0] w;
    w = {op[8:0], ac[3:0], ind[0], idx[3:0], addr[17:0]};
    return w;
  endfunction

  typedef struct packed {
    logic [35:0] w;
    logic [17:0] exp_ea;
    logic [7:0]  exp_reads;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{mkw(184, 3, 0, 0, 5000),   18'd5000,   8'd0},  // R2 no index, r0 loaded
    '{mkw(184, 4, 0, 1, 5000),   18'd5008,   8'd0},  // R3 plain index
    '{mkw(1,   0, 0, 2, 0),      18'h3FFFF,  8'd0},  // R3 all-ones offset
    '{mkw(2,   1, 0, 2, 5),      18'd4,      8'd0},  // R3 wrap
    '{mkw(3,  15, 0, 3, 7),      18'd107,    8'd0},  // R3 left half ignored
    '{mkw(4,   2, 0, 0, 100),    18'd100,    8'd0},  // R2
    '{mkw(5,   6, 1, 0, 16),     18'd1234,   8'd1},  // R4 one level
    '{mkw(6,   7, 1, 0, 17),     18'd108,    8'd1},  // R4 indexed fetched word
    '{mkw(7,   8, 1, 1, 10),     18'd1234,   8'd2},  // R4 indexed then two levels
    '{mkw(511, 9, 1, 0, 19),     18'd1234,   8'd4},  // R4 four levels
    '{mkw(8,  10, 1, 0, 21),     18'd777,    8'd1},  // R5 foreign op/ac in memory
    '{mkw(9,  11, 1, 5, 'h20010),18'd1234,   8'd1}   // R3 wrap into memory
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Memory responder
  initial begin
    logic [17:0] first_addr;
    int wcnt;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    wcnt = 0;
    first_addr = '0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt == 0) first_addr = mem_addr;
        else if (mem_addr != first_addr) addr_moves++;
        if (mem_addr > 18'd63) bad_addr++;
        if (wcnt >= lat) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[mem_addr[5:0]];
          reads++;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  task automatic run_one(input logic [35:0] w, input int l, output int cyc,
                         output logic [17:0] r_ea, output logic [8:0] r_op,
                         output logic [3:0] r_ac, output logic after_done);
    @(negedge clk);
    lat = l; reads = 0;
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    r_ea = ea; r_op = op_out; r_ac = ac_out;
    @(negedge clk);
    after_done = done;
  endtask

  // Watchdog
  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [17:0] r_ea;
    logic [8:0]  r_op;
    logic [3:0]  r_ac;
    logic        after;
    bit          saw_done;

    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) regs[i] = '0;
    regs[0] = {18'd3, 18'd500};
    regs[1] = {18'd0, 18'd8};
    regs[2] = {18'd0, 18'h3FFFF};
    regs[3] = {18'h2AAAA, 18'd100};
    regs[5] = {18'd0, 18'h20000};
    mem[16] = mkw(0, 0, 0, 0, 1234);
    mem[17] = mkw(0, 0, 0, 1, 100);
    mem[18] = mkw(0, 0, 1, 0, 16);
    mem[19] = mkw(0, 0, 1, 1, 12);
    mem[20] = mkw(0, 0, 1, 0, 18);
    mem[21] = mkw(7, 5, 0, 0, 777);
    mem[40] = mkw(0, 0, 1, 0, 40);

    rst_n = 1'b0; start = 1'b0; abort = 1'b0; instr = '0;
    repeat (3) @(negedge clk);
    // R11 during reset
    check(!busy && !done && !mem_req, "R11 outputs in reset", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !mem_req, "R11 outputs after reset", {busy, done, mem_req}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_one(VEC[i].w, i % 3, cyc, r_ea, r_op, r_ac, after);
      check(r_ea == VEC[i].exp_ea, $sformatf("R2/R3/R4 ea vec %0d", i), r_ea, VEC[i].exp_ea);
      check(r_op == VEC[i].w[35:27], $sformatf("R1/R5 op vec %0d", i), r_op, VEC[i].w[35:27]);
      check(r_ac == VEC[i].w[26:23], $sformatf("R1/R5 ac vec %0d", i), r_ac, VEC[i].w[26:23]);
      check(reads == int'(VEC[i].exp_reads), $sformatf("R4 read count vec %0d", i), reads, VEC[i].exp_reads);
      check(after == 1'b0, $sformatf("R7 done width vec %0d", i), after, 0);
      if (VEC[i].exp_reads == 0)
        check(cyc == 2, $sformatf("R6 direct latency vec %0d", i), cyc, 2);
    end
    check(addr_moves == 0, "R8 address stable while requesting", addr_moves, 0);
    check(bad_addr == 0, "R4 memory address in range", bad_addr, 0);

    // R10: second start in the middle of a four-level chain
    @(negedge clk);
    lat = 2; reads = 0;
    instr = mkw(500, 13, 1, 0, 19); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    instr = mkw(83, 2, 0, 0, 999); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    check(ea == 18'd1234, "R10 ea after ignored start", ea, 1234);
    check(op_out == 9'd500, "R10 op after ignored start", op_out, 500);
    check(ac_out == 4'd13, "R10 ac after ignored start", ac_out, 13);
    @(negedge clk);
    check(!busy, "R10 idle after chain", busy, 0);

    // R9: abort an endless self-referencing chain
    @(negedge clk);
    lat = 1;
    instr = mkw(1, 1, 1, 0, 40); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    saw_done = 1'b0;
    repeat (15) begin @(negedge clk); if (done) saw_done = 1'b1; end
    check(busy, "R4 endless chain still busy", busy, 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(!busy && !mem_req && !done, "R9 idle after abort", {busy, mem_req, done}, 0);
    repeat (5) begin @(negedge clk); if (done) saw_done = 1'b1; end
    check(!saw_done, "R9 no done for aborted chain", saw_done, 0);

    // Resolver usable after abort
    run_one(mkw(12, 3, 1, 0, 18), 0, cyc, r_ea, r_op, r_ac, after);
    check(r_ea == 18'd1234, "R4 ea after abort", r_ea, 1234);
    check(r_op == 9'd12, "R5 op after abort", r_op, 12);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule